// File: doc/BRIEF.md
# Keyed Write-Protection Command Decoder

This block sits beside a byte-wide parallel memory and watches every write cycle on its bus (a 15-bit address with an 8-bit data byte). It picks out multi-cycle unlock key sequences. All of them open with the same two steps and then branch into one of four commands: turn write protection on, turn write protection off, erase the whole array, or enter a protection status read. From those commands it drives four outputs. One is a protection latch. One is an erase request held until the erase engine reports completion. One flags the protection status read mode. The last is a permit that tells the array controller a write is a real data write and should go to the cells.

The block also builds the status byte that the memory returns on a status read. That byte carries a data-polling bit, a toggle bit, a page-load-timer flag, a page-abort flag and the protection state. The protection latch takes its value from an input while reset is asserted. A wrapper can feed that input from a non-volatile cell, so the protection state outlasts a loss of power. The array, the program and erase timing engine and the non-volatile cell are outside this block.

Top module: `sdp_cmd_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sdp_en` loads `sdp_init`, and `erase_req`, `stat_mode` and `wr_permit` clear to 0.
- R2: With protection off, a write that is not part of a key sequence raises `wr_permit` for the single cycle after that write.
- R3: A write consumed as a key step (AAh at 5555h, 55h at 2AAAh, or an opcode at 5555h) never raises `wr_permit`.
- R4: The key AAh@5555h, 55h@2AAAh, A0h@5555h sets `sdp_en` to 1. The next write, at any address, is then permitted, and `sdp_en` stays 1 afterwards.
- R5: With protection on, a write not preceded by the key leaves `wr_permit` at 0 and leaves the stored last-written data unchanged.
- R6: The six-step key AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clears `sdp_en` to 0.
- R7: The six-step key AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h sets `erase_req`, which stays 1 until a cycle with `done` high.
- R8: The key AAh@5555h, 55h@2AAAh, 20h@5555h sets `stat_mode`, which clears on the next `rd_strobe`. Bit 0 of `status_byte` always equals `sdp_en`.
- R9: A write that does not match the next expected key step returns the decoder to idle and is handled as an idle-state write. If that write is AAh@5555h, it counts as the first step of a new key.
- R10: Bit 5 of `status_byte` follows `page_tmr`, bit 1 follows `page_abort`, and bits 4 to 2 are 0.
- R11: While `busy` is high, bit 7 of `status_byte` is the inverse of bit 7 of the last permitted write, and bit 6 inverts after each `rd_strobe` (it is 0 after reset). While `busy` is low, bits 7 and 6 equal bits 7 and 6 of the last permitted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdp_init | input | 1 | Protection value loaded during reset |
| wr_valid | input | 1 | A bus write takes place this cycle |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| rd_strobe | input | 1 | A status read takes place this cycle |
| busy | input | 1 | Program or erase in progress |
| done | input | 1 | Erase or write has completed |
| page_tmr | input | 1 | Page load timer running |
| page_abort | input | 1 | Page write aborted |
| sdp_en | output | 1 | Write protection latch |
| erase_req | output | 1 | Whole-array erase requested |
| stat_mode | output | 1 | Protection status read pending |
| wr_permit | output | 1 | Previous write is a real data write |
| status_byte | output | 8 | Status byte for status reads |

## Verification
The bench checks the shared prefix and the third-step branch. A decoder that mixed up the branch would erase when asked to unprotect, or unprotect when asked for a status read. It also breaks key sequences part-way and then sends AAh@5555h again. A decoder that ignored the restart rule would miss the key that follows, and a decoder that forwarded key bytes would raise the permit on them. Under protection it checks that an unkeyed write leaves the polled data bits unchanged, that exactly one write is let through after the unlock key, and that protection is still on afterwards. It also checks that the erase request survives until `done` and that the toggle bit flips on every read while busy.

// File: rtl/sdp_pkg.sv
// Shared types and constants of the keyed command decoder.
// Assumes a byte-wide data bus; key bytes and opcodes are fixed.
package sdp_pkg;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] OP_EXTEND  = 8'h80;
    localparam logic [DATA_W-1:0] OP_PROTECT = 8'hA0;
    localparam logic [DATA_W-1:0] OP_STATUS  = 8'h20;
    localparam logic [DATA_W-1:0] OP_ERASE   = 8'h10;
    localparam logic [DATA_W-1:0] OP_UNPROT  = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_EXT3,
        ST_EXT4,
        ST_EXT5,
        ST_UNLOCK
    } key_state_t;

    typedef struct packed {
        logic protect;
        logic unprotect;
        logic erase;
        logic status;
        logic forward;
    } key_evt_t;
endpackage

// File: rtl/sdp_key_fsm.sv
// Key sequence tracker. Follows the write cycles step by step and emits
// one-cycle command events together with the forward decision for the
// current write. Assumes at most one write per cycle.
module sdp_key_fsm
    import sdp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter logic [ADDR_W-1:0] ADDR_A = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_B = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prot,
    output key_evt_t          evt
);
    key_state_t state, nxt;
    logic hit_first, hit_second, at_a;
    key_state_t fb_state;
    logic fb_fwd;

    // Advance the key state on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Match the current write against the next expected step.
    always_comb begin
        hit_first  = (wr_addr == ADDR_A) && (wr_data == KEY_FIRST);
        hit_second = (wr_addr == ADDR_B) && (wr_data == KEY_SECOND);
        at_a       = (wr_addr == ADDR_A);
        fb_state   = hit_first ? ST_KEY1 : ST_IDLE;
        fb_fwd     = !hit_first && !prot;
        nxt        = state;
        evt        = '0;
        if (wr_valid) begin
            unique case (state)
                ST_IDLE: begin
                    nxt = fb_state; evt.forward = fb_fwd;
                end
                ST_KEY1: begin
                    if (hit_second) nxt = ST_KEY2;
                    else begin nxt = fb_state; evt.forward = fb_fwd; end
                end
                ST_KEY2: begin
                    if (at_a && wr_data == OP_EXTEND) nxt = ST_EXT3;
                    else if (at_a && wr_data == OP_PROTECT) begin
                        nxt = ST_UNLOCK; evt.protect = 1'b1;
                    end else if (at_a && wr_data == OP_STATUS) begin
                        nxt = ST_IDLE; evt.status = 1'b1;
                    end else begin nxt = fb_state; evt.forward = fb_fwd; end
                end
                ST_EXT3: begin
                    nxt = fb_state;
                    if (!hit_first) evt.forward = fb_fwd;
                    if (hit_first) nxt = ST_EXT4;
                end
                ST_EXT4: begin
                    if (hit_second) nxt = ST_EXT5;
                    else begin nxt = fb_state; evt.forward = fb_fwd; end
                end
                ST_EXT5: begin
                    if (at_a && wr_data == OP_ERASE) begin
                        nxt = ST_IDLE; evt.erase = 1'b1;
                    end else if (at_a && wr_data == OP_UNPROT) begin
                        nxt = ST_IDLE; evt.unprotect = 1'b1;
                    end else begin nxt = fb_state; evt.forward = fb_fwd; end
                end
                ST_UNLOCK: begin
                    nxt = ST_IDLE; evt.forward = 1'b1;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // R3: a leading key byte outside the unlock window is never forwarded.
    p_key_not_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_A && wr_data == KEY_FIRST && state != ST_UNLOCK)
        |-> !evt.forward);

    // R5: under protection an idle-state write is dropped.
    p_prot_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && prot && state == ST_IDLE) |-> !evt.forward);

    // R4: the unlock window lasts exactly one write.
    p_unlock_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && state == ST_UNLOCK) |=> (state == ST_IDLE));
endmodule

// File: rtl/sdp_ctrl_regs.sv
// Command state registers: protection latch (loaded from sdp_init in
// reset), erase request held until done, status-read mode, write permit
// and the top two bits of the last permitted write.
module sdp_ctrl_regs
    import sdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sdp_init,
    input  key_evt_t   evt,
    input  logic [1:0] wr_hi,
    input  logic       done,
    input  logic       rd_strobe,
    output logic       sdp_en,
    output logic       erase_req,
    output logic       stat_mode,
    output logic       wr_permit,
    output logic [1:0] last_hi
);
    // Protection latch: set by the protect key, cleared by the unprotect key.
    always_ff @(posedge clk) begin
        if (!rst_n)             sdp_en <= sdp_init;
        else if (evt.protect)   sdp_en <= 1'b1;
        else if (evt.unprotect) sdp_en <= 1'b0;
    end

    // Erase request: raised by the erase key, dropped when the engine is done.
    always_ff @(posedge clk) begin
        if (!rst_n)         erase_req <= 1'b0;
        else if (evt.erase) erase_req <= 1'b1;
        else if (done)      erase_req <= 1'b0;
    end

    // Status-read mode: armed by the status key, consumed by one read.
    always_ff @(posedge clk) begin
        if (!rst_n)          stat_mode <= 1'b0;
        else if (evt.status) stat_mode <= 1'b1;
        else if (rd_strobe)  stat_mode <= 1'b0;
    end

    // Permit pulse and polled data capture for forwarded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_permit <= 1'b0;
            last_hi   <= 2'b00;
        end else begin
            wr_permit <= evt.forward;
            if (evt.forward) last_hi <= wr_hi;
        end
    end

    // R7: an erase request is held until done arrives.
    p_erase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !done) |=> erase_req);

    // R4: protection only rises after a protect event.
    p_sdp_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdp_en) |-> $past(evt.protect));

    // R6: protection only falls after an unprotect event.
    p_sdp_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdp_en) |-> $past(evt.unprotect));
endmodule

// File: rtl/sdp_status_fmt.sv
// Status byte formatter with the read-driven toggle bit. Assumes one
// status read per rd_strobe cycle.
module sdp_status_fmt
    import sdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd_strobe,
    input  logic [1:0]        last_hi,
    input  logic              page_tmr,
    input  logic              page_abort,
    input  logic              sdp_en,
    output logic [DATA_W-1:0] status_byte
);
    logic toggle_q;

    // Toggle bit flips on every status read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                 toggle_q <= 1'b0;
        else if (busy && rd_strobe) toggle_q <= ~toggle_q;
    end

    // Assemble the status byte.
    always_comb begin
        status_byte    = '0;
        status_byte[7] = busy ? ~last_hi[1] : last_hi[1];
        status_byte[6] = busy ? toggle_q : last_hi[0];
        status_byte[5] = page_tmr;
        status_byte[1] = page_abort;
        status_byte[0] = sdp_en;
    end

    // R11: consecutive busy reads see the toggle bit change.
    p_toggle_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe) ##1 busy |-> (status_byte[6] != $past(status_byte[6])));
endmodule

// File: rtl/sdp_cmd_decoder.sv
// Top of the keyed write-protection command decoder. Connects the key
// tracker, the command registers and the status formatter. Assumes the
// bus presents at most one write or one status read per cycle.
module sdp_cmd_decoder
    import sdp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter logic [ADDR_W-1:0] ADDR_A = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_B = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdp_init,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_strobe,
    input  logic              busy,
    input  logic              done,
    input  logic              page_tmr,
    input  logic              page_abort,
    output logic              sdp_en,
    output logic              erase_req,
    output logic              stat_mode,
    output logic              wr_permit,
    output logic [DATA_W-1:0] status_byte
);
    key_evt_t   evt;
    logic [1:0] last_hi;

    sdp_key_fsm #(.ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .prot(sdp_en), .evt(evt)
    );

    sdp_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .sdp_init(sdp_init), .evt(evt),
        .wr_hi(wr_data[DATA_W-1:DATA_W-2]), .done(done), .rd_strobe(rd_strobe),
        .sdp_en(sdp_en), .erase_req(erase_req), .stat_mode(stat_mode),
        .wr_permit(wr_permit), .last_hi(last_hi)
    );

    sdp_status_fmt u_stat (
        .clk(clk), .rst_n(rst_n), .busy(busy), .rd_strobe(rd_strobe),
        .last_hi(last_hi), .page_tmr(page_tmr), .page_abort(page_abort),
        .sdp_en(sdp_en), .status_byte(status_byte)
    );

    // R8: status bit 0 always mirrors the protection latch.
    p_stat_dq0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[0] == sdp_en);

    // R2: a permit pulse always follows a bus write.
    p_permit_after_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> $past(wr_valid));
endmodule

// File: tb/sim_sdp_cmd_decoder.sv
`timescale 1ns/100ps
module sim_sdp_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdp_init = 1'b0;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_strobe = 1'b0;
    logic        busy = 1'b0;
    logic        done = 1'b0;
    logic        page_tmr = 1'b0;
    logic        page_abort = 1'b0;
    logic        sdp_en, erase_req, stat_mode, wr_permit;
    logic [7:0]  status_byte;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit exp_q[$];
    bit exp_tog = 1'b0;

    always #2.5 clk = ~clk;

    sdp_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sdp_init(sdp_init), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .busy(busy), .done(done), .page_tmr(page_tmr), .page_abort(page_abort),
        .sdp_en(sdp_en), .erase_req(erase_req), .stat_mode(stat_mode),
        .wr_permit(wr_permit), .status_byte(status_byte)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Monitor: after each write edge, pop the expected permit and compare (R2/R3/R5).
    always begin
        bit v;
        bit e;
        @(posedge clk);
        v = wr_valid && rst_n;
        #1;
        if (v) begin
            if (exp_q.size() == 0) chk("R2 queue", 8'h1, 8'h0);
            else begin
                e = exp_q.pop_front();
                chk("R2/R3/R5 permit", {7'b0, wr_permit}, {7'b0, e});
            end
        end
    end

    task automatic do_wr(input logic [14:0] a, input logic [7:0] d, input bit exp_p);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        exp_q.push_back(exp_p);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_rd();
        @(negedge clk);
        rd_strobe = 1'b1;
        if (busy) exp_tog = ~exp_tog;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic do_reset(input bit init);
        @(negedge clk);
        rst_n = 1'b0; sdp_init = init;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_tog = 1'b0;
    endtask

    function automatic logic [7:0] exp_stat(input bit b, input bit tg, input logic [1:0] hi,
                                            input bit pt, input bit ab, input bit sdp);
        exp_stat = {b ? ~hi[1] : hi[1], b ? tg : hi[0], pt, 3'b000, ab, sdp};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        // R1 reset state
        chk("R1 reset", {4'b0, sdp_en, erase_req, stat_mode, wr_permit}, 8'h00);
        // R2 unprotected plain write
        do_wr(15'h1234, 8'h85, 1'b1);
        chk("R11 idle polling", status_byte, exp_stat(0, exp_tog, 2'b10, 0, 0, 0));
        // R8 status key; R3 key bytes not forwarded
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h2AAA, 8'h55, 1'b0);
        do_wr(15'h5555, 8'h20, 1'b0);
        chk("R8 stat_mode set", {7'b0, stat_mode}, 8'h01);
        chk("R8 dq0", {7'b0, status_byte[0]}, 8'h00);
        do_rd();
        chk("R8 stat_mode cleared", {7'b0, stat_mode}, 8'h00);
        // R4 protect key, then one permitted write
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h2AAA, 8'h55, 1'b0);
        do_wr(15'h5555, 8'hA0, 1'b0);
        chk("R4 sdp set", {7'b0, sdp_en}, 8'h01);
        do_wr(15'h0100, 8'h40, 1'b1);
        chk("R4 sdp kept", {7'b0, sdp_en}, 8'h01);
        chk("R8 dq0 protected", {7'b0, status_byte[0]}, 8'h01);
        // R5 protected unkeyed write ignored
        do_wr(15'h0200, 8'hFF, 1'b0);
        chk("R5 data unchanged", status_byte, exp_stat(0, exp_tog, 2'b01, 0, 0, 1));
        // R9 broken key falls back; restart on AA@5555
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h2AAA, 8'h55, 1'b0);
        do_wr(15'h5555, 8'h33, 1'b0);
        do_wr(15'h5555, 8'hA0, 1'b0);
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h2AAA, 8'h55, 1'b0);
        do_wr(15'h5555, 8'hA0, 1'b0);
        do_wr(15'h0000, 8'h00, 1'b1);
        chk("R9 restart data stored", status_byte, exp_stat(0, exp_tog, 2'b00, 0, 0, 1));
        // R11 busy polling and toggle
        busy = 1'b1;
        @(negedge clk);
        chk("R11 busy read 1", status_byte, exp_stat(1, exp_tog, 2'b00, 0, 0, 1));
        do_rd();
        chk("R11 busy read 2", status_byte, exp_stat(1, exp_tog, 2'b00, 0, 0, 1));
        do_rd();
        chk("R11 busy read 3", status_byte, exp_stat(1, exp_tog, 2'b00, 0, 0, 1));
        busy = 1'b0;
        // R10 flag bits
        page_tmr = 1'b1; page_abort = 1'b1;
        @(negedge clk);
        chk("R10 flags", status_byte, exp_stat(0, exp_tog, 2'b00, 1, 1, 1));
        page_tmr = 1'b0; page_abort = 1'b0;
        // R7 erase key and hold until done
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h2AAA, 8'h55, 1'b0);
        do_wr(15'h5555, 8'h80, 1'b0);
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h2AAA, 8'h55, 1'b0);
        do_wr(15'h5555, 8'h10, 1'b0);
        chk("R7 erase set", {7'b0, erase_req}, 8'h01);
        chk("R7 erase keeps sdp", {7'b0, sdp_en}, 8'h01);
        repeat (4) @(negedge clk);
        chk("R7 erase held", {7'b0, erase_req}, 8'h01);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R7 erase cleared", {7'b0, erase_req}, 8'h00);
        // R6 unprotect key
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h2AAA, 8'h55, 1'b0);
        do_wr(15'h5555, 8'h80, 1'b0);
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h2AAA, 8'h55, 1'b0);
        do_wr(15'h5555, 8'h20, 1'b0);
        chk("R6 sdp cleared", {7'b0, sdp_en}, 8'h00);
        chk("R6 no erase", {7'b0, erase_req}, 8'h00);
        // R9 unprotected mismatch is forwarded as a plain write
        do_wr(15'h5555, 8'hAA, 1'b0);
        do_wr(15'h0000, 8'hC0, 1'b1);
        chk("R9 fallback stored", status_byte, exp_stat(0, exp_tog, 2'b11, 0, 0, 0));
        do_wr(15'h0042, 8'h17, 1'b1);
        // R1 retained protection from sdp_init
        do_reset(1'b1);
        chk("R1 reset with init", {4'b0, sdp_en, erase_req, stat_mode, wr_permit}, 8'h08);
        do_wr(15'h0042, 8'h17, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 queue drained", 8'(exp_q.size()), 8'h00);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule